// File: doc/BRIEF.md
# Control-Register Port Access Sequencer

This block sits between a host register bus and a handshaked control-register port. The port has a 16-bit data/offset bus, four request strobes and an acknowledge line. On that port every step is a four-edge handshake: the requester raises a strobe, the target raises acknowledge, the requester drops the strobe, and the target drops acknowledge. The host sees a small register window. A manual control word drives the strobes directly. A status word reflects the port's read bus and acknowledge line. A base register and a count register, together with a launch register, let the hardware run a whole transaction by itself.

A launched write runs the address, capture-data and commit steps in order. A launched read burst runs an address step and a read step for each offset in turn, and queues each result with its offset in a small buffer that the consumer drains through a valid/ready pair. Every wait for an acknowledge edge has a cycle bound. A missing or stuck acknowledge ends the sequence with an error and does not hang the block. The bound is a parameter, so a simulation can shorten it.

Top module: `crport_sequencer`

## Requirements
- R1: After reset, busy and err are low, all four strobes are low, the base register reads 0 and the count register reads 1.
- R2: Register window (reg_addr): 0 = manual control word, 1 = status, 2 = base, 3 = count, 4 = launch. Writes complete in the cycle reg_valid is high (reg_ready is always high), and read data is combinational. In the control word, bits 15:0 carry the data/offset, and bits 16, 17, 18 and 19 are capture-address, capture-data, write and read. While idle, the control word drives the port directly. In the status word, bits 15:0 are the port read bus, bit 16 is acknowledge, bit 17 is busy and bit 18 is err. A launch write with bit 0 set starts a sequence. Bit 1 selects write (1) or read burst (0), and bits 31:16 give the write value.
- R3: A launched write asserts capture-address with the base on the data bus, then capture-data with the value, then write with the value. Each step holds its strobe until acknowledge is seen high, and the next step begins only after acknowledge is seen low.
- R4: A read burst covers offsets base, base+1, …, base+count−1 in increasing order. For each offset it pushes one buffer entry that holds the offset and the data that was on the read bus while acknowledge was high during the read step.
- R5: A launch is rejected if the base exceeds 0x201F, or if a read burst has a count of 0 or a count above 0x42. On rejection err rises at the accepting edge, busy stays low and no strobe is driven.
- R6: If acknowledge does not reach the awaited level within TIMEOUT cycles, the sequence is abandoned: busy falls, err rises, and all strobes go low. If acknowledge never rises on the first step, busy is high for exactly TIMEOUT cycles.
- R7: Busy is high from an accepted launch until the sequence completes or fails. While busy, writes to the control, base, count and launch registers are ignored.
- R8: When the result buffer is full, the sequencer holds before the next address step. No strobe is driven and no entry is lost. It resumes once the consumer frees space.
- R9: err stays set until the next launch, which clears it if that launch is accepted.
- R10: While busy, at most one strobe is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Host register access request |
| reg_ready | output | 1 | Always high; access completes in the same cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cr_data_in | output | 16 | Data/offset bus toward the port |
| cr_cap_addr | output | 1 | Capture-address strobe |
| cr_cap_data | output | 1 | Capture-data strobe |
| cr_write | output | 1 | Commit-write strobe |
| cr_read | output | 1 | Read strobe |
| cr_data_out | input | 16 | Read bus from the port |
| cr_ack | input | 1 | Port acknowledge |
| rd_valid | output | 1 | Result buffer not empty |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_offset | output | 16 | Offset of the head entry |
| rd_data | output | 16 | Data of the head entry |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last launch was rejected or timed out |

## Verification
The hardest state to reach from the ports is a sequencer that is parked with a full result buffer between two offsets. Reaching it needs a burst longer than the buffer and a consumer that withholds ready. The bench holds rd_ready low through a six-register burst, counts address strobes to confirm that exactly one read past the buffer depth has finished, and then releases ready and checks that every entry arrives in order. The timeout paths need an acknowledge that misbehaves, so the bench's port model can be told to never raise acknowledge, or to never drop it, with the timeout parameter shortened to 16 cycles.

// File: rtl/crp_pkg.sv
// Shared types and register-window constants for the control-port sequencer.
// Assumes a 16-bit port data bus and a 32-bit host register bus.
package crp_pkg;

    localparam int CR_W = 16;

    // Host register window
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_BASE  = 3'd2;
    localparam logic [2:0] RA_COUNT = 3'd3;
    localparam logic [2:0] RA_GO    = 3'd4;

    // Step kinds of a port transaction
    typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_WRITE, PH_READ} phase_e;

    // Sequencer states: strobe high, strobe released, waiting for buffer space
    typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_PUSH} seq_state_e;

    // Packed so that bit 0..3 match control-word bits 16..19
    typedef struct packed {
        logic rd;
        logic wr;
        logic cap_data;
        logic cap_addr;
    } strobe_t;

    typedef struct packed {
        logic [CR_W-1:0] off;
        logic [CR_W-1:0] data;
    } rd_entry_t;

endpackage

// File: rtl/crp_regs.sv
// Host register window: manual control word, status, base, count and launch.
// Assumes single-cycle accesses (ready tied high) and that the launch pulse
// is consumed by an engine that is idle whenever busy is low.
module crp_regs
    import crp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_valid,
    input  logic            reg_write,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            busy,
    input  logic            err,
    input  logic [CR_W-1:0] port_dout,
    input  logic            port_ack,
    output strobe_t         man_strobe,
    output logic [CR_W-1:0] man_data,
    output logic [CR_W-1:0] base_q,
    output logic [CR_W-1:0] count_q,
    output logic            go,
    output logic            go_wr,
    output logic [CR_W-1:0] go_val
);

    logic [19:0] ctrl_q;
    logic        wr_ok;

    // Writes are accepted only while no sequence runs
    always_comb wr_ok = reg_valid && reg_write && !busy;

    // Register updates for the writable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            base_q  <= '0;
            count_q <= CR_W'(1);
        end else if (wr_ok) begin
            case (reg_addr)
                RA_CTRL:  ctrl_q  <= reg_wdata[19:0];
                RA_BASE:  base_q  <= reg_wdata[CR_W-1:0];
                RA_COUNT: count_q <= reg_wdata[CR_W-1:0];
                default:  ;
            endcase
        end
    end

    // Launch decode
    always_comb begin
        go     = wr_ok && (reg_addr == RA_GO) && reg_wdata[0];
        go_wr  = reg_wdata[1];
        go_val = reg_wdata[31:16];
    end

    // Manual strobes and data come straight from the control word
    always_comb begin
        man_strobe = strobe_t'(ctrl_q[19:16]);
        man_data   = ctrl_q[15:0];
    end

    // Read mux
    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {12'd0, ctrl_q};
            RA_STAT:  reg_rdata = {13'd0, err, busy, port_ack, port_dout};
            RA_BASE:  reg_rdata = {16'd0, base_q};
            RA_COUNT: reg_rdata = {16'd0, count_q};
            default:  reg_rdata = '0;
        endcase
    end

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_valid && reg_write && reg_addr == RA_BASE) |=> $stable(base_q));

endmodule

// File: rtl/crp_fifo.sv
// Result buffer: a first-in first-out queue with valid/ready on the read side.
// Assumes DEPTH is a power of two; the writer never pushes while full.
module crp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;
    logic         pop;

    // Occupancy flags from the wrap-extended pointers
    always_comb begin
        full     = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
        rd_valid = (wp_q != rp_q);
        pop      = rd_valid && rd_ready;
        rd_data  = mem[rp_q[AW-1:0]];
    end

    // Pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_en) wp_q <= wp_q + 1'b1;
            if (pop)   rp_q <= rp_q + 1'b1;
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
    end

    // R8
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

endmodule

// File: rtl/crp_engine.sv
// Handshake sequencer: runs address/capture/commit steps or read bursts on the
// control-register port, bounding every acknowledge wait by TIMEOUT cycles.
// Assumes go only pulses while busy is low and that fifo_full is registered.
module crp_engine
    import crp_pkg::*;
#(
    parameter int MAX_COUNT = 66,
    parameter int MAX_BASE  = 32'h201F,
    parameter int TIMEOUT   = 500000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            go_wr,
    input  logic [CR_W-1:0] go_val,
    input  logic [CR_W-1:0] base,
    input  logic [CR_W-1:0] count,
    input  logic            port_ack,
    input  logic [CR_W-1:0] port_dout,
    input  logic            fifo_full,
    output logic            busy,
    output logic            err,
    output strobe_t         seq_strobe,
    output logic [CR_W-1:0] seq_data,
    output logic            push,
    output rd_entry_t       push_entry
);

    localparam int          TW     = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

    seq_state_e      state_q;
    phase_e          phase_q;
    logic [CR_W-1:0] off_q, left_q, wval_q, rdat_q;
    logic [TW-1:0]   timer_q;
    logic            is_wr_q, busy_q, err_q;
    logic            bad_cmd, at_level, timer_exp;

    // Launch validation against the offset and count limits
    always_comb begin
        bad_cmd = (base > CR_W'(MAX_BASE)) ||
                  (!go_wr && ((count == '0) || (count > CR_W'(MAX_COUNT))));
    end

    // Awaited acknowledge level for the current wait and its deadline
    always_comb begin
        at_level  = (state_q == S_HI) ? port_ack : !port_ack;
        timer_exp = (timer_q == T_LAST);
    end

    // Main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_ADDR;
            off_q   <= '0;
            left_q  <= '0;
            wval_q  <= '0;
            rdat_q  <= '0;
            timer_q <= '0;
            is_wr_q <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (go) begin
                        err_q <= bad_cmd;
                        if (!bad_cmd) begin
                            busy_q  <= 1'b1;
                            state_q <= S_HI;
                            phase_q <= PH_ADDR;
                            off_q   <= base;
                            left_q  <= count;
                            is_wr_q <= go_wr;
                            wval_q  <= go_val;
                            timer_q <= '0;
                        end
                    end
                end
                S_HI, S_LO: begin
                    if (at_level) begin
                        timer_q <= '0;
                        if (state_q == S_HI) begin
                            if (phase_q == PH_READ) rdat_q <= port_dout;
                            state_q <= S_LO;
                        end else begin
                            case (phase_q)
                                PH_ADDR: begin
                                    phase_q <= is_wr_q ? PH_DATA : PH_READ;
                                    state_q <= S_HI;
                                end
                                PH_DATA: begin
                                    phase_q <= PH_WRITE;
                                    state_q <= S_HI;
                                end
                                PH_WRITE: begin
                                    state_q <= S_IDLE;
                                    busy_q  <= 1'b0;
                                end
                                default: state_q <= S_PUSH;
                            endcase
                        end
                    end else if (timer_exp) begin
                        state_q <= S_IDLE;
                        busy_q  <= 1'b0;
                        err_q   <= 1'b1;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: begin
                    if (!fifo_full) begin
                        if (left_q == CR_W'(1)) begin
                            state_q <= S_IDLE;
                            busy_q  <= 1'b0;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            off_q   <= off_q + 1'b1;
                            phase_q <= PH_ADDR;
                            state_q <= S_HI;
                        end
                    end
                end
            endcase
        end
    end

    // Strobe and bus drive for the current step
    always_comb begin
        seq_strobe = '0;
        if (state_q == S_HI) begin
            case (phase_q)
                PH_ADDR:  seq_strobe.cap_addr = 1'b1;
                PH_DATA:  seq_strobe.cap_data = 1'b1;
                PH_WRITE: seq_strobe.wr       = 1'b1;
                default:  seq_strobe.rd       = 1'b1;
            endcase
        end
        seq_data = ((phase_q == PH_DATA) || (phase_q == PH_WRITE)) ? wval_q : off_q;
    end

    // Buffer push and flag outputs
    always_comb begin
        push       = (state_q == S_PUSH) && !fifo_full;
        push_entry = '{off: off_q, data: rdat_q};
        busy       = busy_q;
        err        = err_q;
    end

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bad_cmd) |=> (err_q && !busy_q));

    // R6
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == S_HI) || (state_q == S_LO)) && !at_level && timer_exp)
        |=> (err_q && !busy_q));

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|seq_strobe) |-> ($past(port_ack) || err_q));

    // R4
    off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && (off_q != $past(off_q)))
        |-> (off_q == $past(off_q) + 16'd1));

endmodule

// File: rtl/crport_sequencer.sv
// Top: host register window, handshake sequencer and result buffer for a
// control-register port. The port follows the manual control word while idle
// and the sequencer while busy.
module crport_sequencer
    import crp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_COUNT  = 66,
    parameter int MAX_BASE   = 32'h201F,
    parameter int TIMEOUT    = 500000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    output logic        reg_ready,
    input  logic        reg_write,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [15:0] cr_data_in,
    output logic        cr_cap_addr,
    output logic        cr_cap_data,
    output logic        cr_write,
    output logic        cr_read,
    input  logic [15:0] cr_data_out,
    input  logic        cr_ack,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [15:0] rd_offset,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        err
);

    localparam int ENTRY_W = $bits(rd_entry_t);

    strobe_t          man_strobe, seq_strobe, port_strobe;
    logic [CR_W-1:0]  man_data, seq_data, base_q, count_q, go_val;
    logic             go, go_wr, push, fifo_full, eng_busy, eng_err;
    rd_entry_t        push_entry, head;

    crp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (eng_busy),
        .err        (eng_err),
        .port_dout  (cr_data_out),
        .port_ack   (cr_ack),
        .man_strobe (man_strobe),
        .man_data   (man_data),
        .base_q     (base_q),
        .count_q    (count_q),
        .go         (go),
        .go_wr      (go_wr),
        .go_val     (go_val)
    );

    crp_engine #(
        .MAX_COUNT (MAX_COUNT),
        .MAX_BASE  (MAX_BASE),
        .TIMEOUT   (TIMEOUT)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_wr      (go_wr),
        .go_val     (go_val),
        .base       (base_q),
        .count      (count_q),
        .port_ack   (cr_ack),
        .port_dout  (cr_data_out),
        .fifo_full  (fifo_full),
        .busy       (eng_busy),
        .err        (eng_err),
        .seq_strobe (seq_strobe),
        .seq_data   (seq_data),
        .push       (push),
        .push_entry (push_entry)
    );

    crp_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (ENTRY_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (push_entry),
        .full     (fifo_full),
        .rd_valid (rd_valid),
        .rd_ready (rd_ready),
        .rd_data  (head)
    );

    // Port ownership: sequencer while busy, manual word otherwise
    always_comb begin
        port_strobe = eng_busy ? seq_strobe : man_strobe;
        cr_data_in  = eng_busy ? seq_data   : man_data;
        cr_cap_addr = port_strobe.cap_addr;
        cr_cap_data = port_strobe.cap_data;
        cr_write    = port_strobe.wr;
        cr_read     = port_strobe.rd;
        rd_offset   = head.off;
        rd_data     = head.data;
        busy        = eng_busy;
        err         = eng_err;
        reg_ready   = 1'b1;
    end

    // R10
    port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> $onehot0({cr_read, cr_write, cr_cap_data, cr_cap_addr}));

endmodule

// File: tb/sim_crport_sequencer.sv
module sim_crport_sequencer;

    localparam int TO    = 16;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0, rd_ready = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic [15:0] cr_data_in, cr_data_out, rd_offset, rd_data;
    logic        cr_cap_addr, cr_cap_data, cr_write, cr_read, cr_ack;
    logic        rd_valid, busy, err;

    always #4 clk = ~clk;

    crport_sequencer #(
        .FIFO_DEPTH (DEPTH),
        .MAX_COUNT  (66),
        .MAX_BASE   (32'h201F),
        .TIMEOUT    (TO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cr_data_in(cr_data_in), .cr_cap_addr(cr_cap_addr),
        .cr_cap_data(cr_cap_data), .cr_write(cr_write), .cr_read(cr_read),
        .cr_data_out(cr_data_out), .cr_ack(cr_ack), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_offset(rd_offset), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] seed(int i);
        return 16'h3C00 ^ 16'(i * 257);
    endfunction

    // Port target model: 4-edge handshake with programmable misbehaviour
    int          ack_dly = 0;
    bit          never_hi = 1'b0, never_lo = 1'b0;
    logic [15:0] pmem [0:127];
    logic [15:0] p_addr, p_dreg;
    int          p_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            cr_ack      <= 1'b0;
            cr_data_out <= '0;
            p_cnt       <= 0;
            p_addr      <= '0;
            p_dreg      <= '0;
            for (int i = 0; i < 128; i++) pmem[i] <= seed(i);
        end else if (cr_cap_addr | cr_cap_data | cr_write | cr_read) begin
            if (!cr_ack) begin
                if (p_cnt < ack_dly) p_cnt <= p_cnt + 1;
                else if (!never_hi) begin
                    cr_ack <= 1'b1;
                    p_cnt  <= 0;
                    if (cr_cap_addr) p_addr <= cr_data_in;
                    if (cr_cap_data) p_dreg <= cr_data_in;
                    if (cr_write)    pmem[p_addr[6:0]] <= p_dreg;
                    if (cr_read)     cr_data_out <= pmem[p_addr[6:0]];
                end
            end
        end else begin
            p_cnt <= 0;
            if (cr_ack && !never_lo) cr_ack <= 1'b0;
        end
    end

    // Monitor: strobe rise log, address-strobe count, multi-strobe, collector
    logic [3:0]  mon_s, prev_s = '0;
    int          log_code[$];
    logic [15:0] log_din[$];
    logic [15:0] got_off[$], got_dat[$];
    int          rises_addr = 0, multi = 0;

    always @(negedge clk) begin
        mon_s = {cr_read, cr_write, cr_cap_data, cr_cap_addr};
        for (int k = 0; k < 4; k++) begin
            if (mon_s[k] && !prev_s[k]) begin
                log_code.push_back(k);
                log_din.push_back(cr_data_in);
                if (k == 0) rises_addr++;
            end
        end
        if (busy && $countones(mon_s) > 1) multi++;
        prev_s = mon_s;
        if (rd_valid && rd_ready) begin
            got_off.push_back(rd_offset);
            got_dat.push_back(rd_data);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        tick(1);
        reg_valid = 1'b0;
    endtask

    task automatic start(logic op, logic [15:0] b, logic [15:0] c, logic [15:0] v, int dly);
        ack_dly = dly;
        reg_wr(3'd2, {16'd0, b});
        reg_wr(3'd3, {16'd0, c});
        log_code.delete(); log_din.delete();
        got_off.delete(); got_dat.delete();
        rises_addr = 0;
        reg_wr(3'd4, {v, 14'd0, op, 1'b1});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && busy; k++) tick(1);
        tick(DEPTH + 4);
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] base;
        logic [15:0] cnt;
        logic [15:0] val;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 16'd1,  16'h0000, 4'd0},
        '{1'b1, 16'h0005, 16'd1,  16'hBEEF, 4'd1},
        '{1'b0, 16'h0003, 16'd4,  16'h0000, 4'd2},
        '{1'b1, 16'h201F, 16'd1,  16'h1234, 4'd0},
        '{1'b0, 16'h201C, 16'd4,  16'h0000, 4'd3},
        '{1'b0, 16'h0010, 16'h42, 16'h0000, 4'd0},
        '{1'b1, 16'h0040, 16'd1,  16'h0F0F, 4'd5},
        '{1'b0, 16'h003E, 16'd4,  16'h0000, 4'd0}
    };

    logic [15:0] exp_mem [0:127];

    task automatic check_burst(string tag, logic [15:0] b, int c);
        chk({tag, " entry count"}, got_off.size(), c);
        if (got_off.size() == c) begin
            for (int i = 0; i < c; i++) begin
                chk({tag, " offset"}, got_off[i], 16'(b + i));
                chk({tag, " data"}, got_dat[i], exp_mem[7'(b + i)]);
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        for (int i = 0; i < 128; i++) exp_mem[i] = seed(i);
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 strobes", {cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
        reg_rd(3'd2, rd); chk("R1 base", rd, 0);
        reg_rd(3'd3, rd); chk("R1 count", rd, 1);

        // Vector walk: R3 writes, R4 read bursts
        for (int v = 0; v < NV; v++) begin
            start(VECS[v].wr, VECS[v].base, VECS[v].cnt, VECS[v].val, int'(VECS[v].dly));
            wait_idle();
            chk("R6 no error on good sequence", err, 0);
            if (VECS[v].wr) begin
                chk("R3 step count", log_code.size(), 3);
                if (log_code.size() == 3) begin
                    chk("R3 first step capture-address", log_code[0], 0);
                    chk("R3 second step capture-data", log_code[1], 1);
                    chk("R3 third step write", log_code[2], 2);
                    chk("R3 offset on bus", log_din[0], VECS[v].base);
                    chk("R3 value on bus", log_din[1], VECS[v].val);
                    chk("R3 value at commit", log_din[2], VECS[v].val);
                end
                exp_mem[VECS[v].base[6:0]] = VECS[v].val;
            end else begin
                check_burst("R4", VECS[v].base, int'(VECS[v].cnt));
            end
        end

        // R5 rejections, R9 sticky error
        start(1'b0, 16'h0000, 16'd0, 16'h0, 0);
        chk("R5 count zero err", err, 1);
        chk("R5 count zero busy", busy, 0);
        tick(5);
        chk("R5 count zero no strobe", rises_addr, 0);
        chk("R9 error sticky", err, 1);
        reg_rd(3'd1, rd); chk("R2 status err bit 18", rd[18], 1);
        start(1'b0, 16'h0000, 16'h43, 16'h0, 0);
        chk("R5 count over limit err", err, 1);
        chk("R5 count over limit busy", busy, 0);
        tick(5);
        chk("R5 count over limit no strobe", rises_addr, 0);
        start(1'b1, 16'h2020, 16'd1, 16'h5555, 0);
        chk("R5 base over limit err", err, 1);
        tick(5);
        chk("R5 base over limit no strobe", rises_addr + log_code.size(), 0);
        start(1'b0, 16'h0001, 16'd1, 16'h0, 0);
        chk("R9 error cleared by accepted launch", err, 0);
        chk("R7 busy after launch", busy, 1);
        wait_idle();
        check_burst("R9 follow-up read", 16'h0001, 1);

        // R7 writes and launches ignored while busy
        start(1'b1, 16'h0022, 16'd1, 16'hA55A, 6);
        chk("R7 busy during write", busy, 1);
        reg_wr(3'd2, 32'h0033);
        reg_wr(3'd4, 32'h0000_0001);
        reg_wr(3'd0, 32'h0008_0000);
        wait_idle();
        reg_rd(3'd2, rd); chk("R7 base unchanged", rd, 32'h22);
        chk("R7 no second sequence", rises_addr, 1);
        chk("R7 control write ignored", {cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
        exp_mem[7'h22] = 16'hA55A;
        start(1'b0, 16'h0022, 16'd1, 16'h0, 0);
        wait_idle();
        check_burst("R3 written value read back", 16'h0022, 1);

        // R6 acknowledge never rises: busy for exactly TO cycles
        never_hi = 1'b1;
        start(1'b1, 16'h0002, 16'd1, 16'h7777, 0);
        n = 0;
        while (busy && n < 100) begin
            n++;
            tick(1);
        end
        chk("R6 busy length", n, TO);
        chk("R6 err after timeout", err, 1);
        chk("R6 strobes released", {cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
        never_hi = 1'b0;
        tick(3);

        // R6 acknowledge stuck high
        never_lo = 1'b1;
        start(1'b0, 16'h0004, 16'd1, 16'h0, 0);
        for (int k = 0; k < 100 && busy; k++) tick(1);
        chk("R6 stuck-high busy", busy, 0);
        chk("R6 stuck-high err", err, 1);
        tick(3);
        chk("R6 stuck-high no result", got_off.size(), 0);
        never_lo = 1'b0;
        tick(3);

        // R8 stall on full buffer
        rd_ready = 1'b0;
        start(1'b0, 16'h0008, 16'd6, 16'h0, 0);
        tick(80);
        chk("R8 stalled busy", busy, 1);
        chk("R8 reads before stall", rises_addr, DEPTH + 1);
        chk("R8 no strobe while stalled", {cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
        chk("R8 nothing delivered", got_off.size(), 0);
        rd_ready = 1'b1;
        wait_idle();
        check_burst("R8", 16'h0008, 6);

        // R2 manual control word and status
        reg_wr(3'd0, 32'h0001_0045);
        chk("R2 manual capture-address", cr_cap_addr, 1);
        chk("R2 manual bus", cr_data_in, 16'h0045);
        tick(4);
        reg_rd(3'd1, rd);
        chk("R2 status ack bit 16", rd[16], 1);
        chk("R2 status busy bit 17", rd[17], 0);
        reg_rd(3'd0, rd); chk("R2 control readback", rd, 32'h0001_0045);
        reg_wr(3'd0, 32'h0);
        tick(4);
        reg_rd(3'd1, rd); chk("R2 status ack low", rd[16], 0);
        reg_wr(3'd0, 32'h0008_0000);
        tick(4);
        reg_rd(3'd1, rd); chk("R2 status read bus", rd[15:0], exp_mem[7'h45]);
        reg_wr(3'd0, 32'h0);
        tick(4);

        // R10 single strobe while busy
        chk("R10 multiple strobes seen", multi, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule